// File: doc/BRIEF.md
# Preemptive rotating bus arbiter

This block decides which master owns a shared system bus. Every master has an active-low request line into the arbiter and an active-low acknowledge line out of it. The masters are the host CPU, a memory refresh controller, a DMA controller and a parameterised number of slot bus masters (up to fifteen). A master holds the bus for as long as its acknowledge is low. When the bus changes hands, it passes to the next requesting master in a rotating order, so no master can keep the others off the bus for good.

When another master wants the bus, the arbiter does not take it away at once. It withdraws the current owner's acknowledge and then waits for the owner to give the bus back by releasing its request. A watchdog times that wait. Its limit depends on the kind of owner: a DMA controller running enhanced cycles gets a shorter window than the other masters. A DMA controller running compatibility cycles is never preempted. If an owner keeps its request past the limit, the arbiter pulses bus reset and NMI for one clock and then gives the bus to the CPU. The CPU is the default owner after reset and whenever nobody else is asking.

Master index map, used on both vectors: 0 = CPU, 1 = refresh, 2 = DMA, 3+k = slot master k.

Top module: `busown_arbiter`

## Requirements
- R1: After reset, only ack_n[0] (CPU) is low, and bus_rst and nmi are low.
- R2: If the owner's request is high (not requesting) at a clock edge and another master requests, that master's acknowledge goes low after that edge and the old owner's acknowledge goes high.
- R3: If the owner holds its request and any other master requests at a clock edge, the owner's acknowledge goes high after that edge. All acknowledges then stay high until the owner releases or the wait times out.
- R4: When a preempted owner's request is seen high at a clock edge, the next requester is acknowledged after that edge.
- R5: The next owner is the first requesting master found by searching upward from the current owner's index, wrapping from the highest index to 0.
- R6: For slot, refresh and CPU owners, a release seen at or before the 64th clock edge after the edge that withdrew the acknowledge is honoured normally. A request still held at that 64th edge is a timeout.
- R7: For the DMA owner with dma_compat low, the same window is 32 clock edges.
- R8: On a timeout, bus_rst and nmi are high for exactly one clock with every acknowledge high. In the following clock the CPU's acknowledge is low.
- R9: While dma_compat is high and the DMA owner holds its request, its acknowledge is never withdrawn, no matter how long other masters request.
- R10: At most one acknowledge is low at any time.
- R11: When the owner releases and no other master requests, the bus returns to the CPU on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NSLOT+3 | Active-low bus requests, indexed per the master map |
| dma_compat | input | 1 | High when the DMA controller runs compatibility cycles (not preemptible) |
| ack_n | output | NSLOT+3 | Active-low bus acknowledges, indexed per the master map |
| bus_rst | output | 1 | One-clock bus reset pulse on a release timeout |
| nmi | output | 1 | One-clock non-maskable interrupt pulse on a release timeout |

## Verification
The bench targets the edges of the release window. A release seen on exactly the 64th edge must be honoured, while a request still held there must time out. A counter that is off by one either resets a master that did let go or gives a stuck master an extra clock. The DMA timeout is checked on its own, shorter limit, which catches a design that applies one limit to every owner. The bench also checks that the rotation wraps past the top index to refresh instead of restarting at slot 0. Finally, it holds a compatibility-mode DMA owner against a competing request for a long stretch, which exposes a design that preempts it or lets its watchdog run.

// File: rtl/busown_pkg.sv
package busown_pkg;
  localparam int unsigned IDX_CPU   = 0;
  localparam int unsigned IDX_REF   = 1;
  localparam int unsigned IDX_DMA   = 2;
  localparam int unsigned IDX_SLOT0 = 3;

  typedef enum logic [1:0] {
    ST_OWN     = 2'd0,
    ST_PREEMPT = 2'd1,
    ST_RECOVER = 2'd2
  } arb_state_e;
endpackage

// File: rtl/busown_pick.sv
// Rotating search: first set candidate strictly after base, wrapping.
module busown_pick #(
  parameter int unsigned N = 9,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [IW-1:0] base,
  output logic          hit,
  output logic [IW-1:0] sel
);
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int unsigned k = 1; k <= N; k++) begin
      int unsigned pos;
      pos = (int'(base) + k) % N;
      if (!hit && cand[pos]) begin
        hit = 1'b1;
        sel = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/busown_timer.sv
// Counts edges spent waiting for a release; expired on the limit-th edge.
module busown_timer #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter
  import busown_pkg::*;
#(
  parameter int unsigned NSLOT     = 6,
  parameter int unsigned LIM_SLOT  = 64,
  parameter int unsigned LIM_DMA   = 32,
  parameter int unsigned LIM_OTHER = 64,
  localparam int unsigned N    = NSLOT + 3,
  localparam int unsigned IW   = $clog2(N),
  localparam int unsigned LMAX = (LIM_SLOT > LIM_DMA) ?
                                 ((LIM_SLOT > LIM_OTHER) ? LIM_SLOT : LIM_OTHER) :
                                 ((LIM_DMA > LIM_OTHER) ? LIM_DMA : LIM_OTHER),
  localparam int unsigned CW   = $clog2(LMAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         dma_compat,
  output logic [N-1:0] ack_n,
  output logic         bus_rst,
  output logic         nmi
);
  arb_state_e    state;
  logic [IW-1:0] owner;
  logic [N-1:0]  req;
  logic [N-1:0]  owner_bit;
  logic [N-1:0]  others;
  logic          other_hit;
  logic [IW-1:0] other_sel;
  logic [IW-1:0] next_owner;
  logic          owner_req;
  logic          preemptable;
  logic [CW-1:0] limit;
  logic          wait_run;
  logic          expired;

  assign req         = ~req_n;
  assign owner_bit   = N'(1) << owner;
  assign others      = req & ~owner_bit;
  assign owner_req   = |(req & owner_bit);
  assign next_owner  = other_hit ? other_sel : IW'(IDX_CPU);
  assign preemptable = !((int'(owner) == IDX_DMA) && dma_compat);

  always_comb begin
    if (int'(owner) == IDX_DMA)         limit = CW'(LIM_DMA);
    else if (int'(owner) >= IDX_SLOT0)  limit = CW'(LIM_SLOT);
    else                                limit = CW'(LIM_OTHER);
  end

  assign wait_run = (state == ST_PREEMPT) && owner_req;

  busown_pick #(.N(N)) u_pick (
    .cand (others),
    .base (owner),
    .hit  (other_hit),
    .sel  (other_sel)
  );

  busown_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wait_run),
    .limit   (limit),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OWN;
      owner <= IW'(IDX_CPU);
    end else begin
      case (state)
        ST_OWN: begin
          if (!owner_req)                    owner <= next_owner;
          else if (other_hit && preemptable) state <= ST_PREEMPT;
        end
        ST_PREEMPT: begin
          if (!owner_req) begin
            owner <= next_owner;
            state <= ST_OWN;
          end else if (expired) begin
            state <= ST_RECOVER;
          end
        end
        default: begin
          owner <= IW'(IDX_CPU);
          state <= ST_OWN;
        end
      endcase
    end
  end

  assign ack_n   = (state == ST_OWN) ? ~owner_bit : '1;
  assign bus_rst = (state == ST_RECOVER);
  assign nmi     = (state == ST_RECOVER);
endmodule

// File: rtl/busown_arbiter_chk.sv
module busown_arbiter_chk #(
  parameter int unsigned NSLOT = 6,
  localparam int unsigned N = NSLOT + 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_n,
  input logic         dma_compat,
  input logic [N-1:0] ack_n,
  input logic         bus_rst,
  input logic         nmi
);
  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ack_n));

  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |-> (nmi && (&ack_n)));

  // R8
  rst_then_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (!bus_rst && !ack_n[0]));

  // R9
  compat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n[2] && !req_n[2] && dma_compat) |=> !ack_n[2]);

  for (genvar i = 1; i < N; i++) begin : g_per
    // R2
    grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n[i]) |-> !$past(req_n[i]));

    // R3
    preempt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ack_n[i]) && !$past(req_n[i])) |->
        $past(|(~req_n & ~(N'(1) << i))));
  end
endmodule

bind busown_arbiter busown_arbiter_chk #(.NSLOT(NSLOT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_n      (req_n),
  .dma_compat (dma_compat),
  .ack_n      (ack_n),
  .bus_rst    (bus_rst),
  .nmi        (nmi)
);

// File: tb/busown_arbiter_test.sv
module busown_arbiter_test;
  localparam int unsigned TCK      = 10;
  localparam int unsigned NSLOT    = 6;
  localparam int unsigned N        = NSLOT + 3;
  localparam int unsigned SLOT_LIM = 64;
  localparam int unsigned DMA_LIM  = 32;
  localparam logic [N-1:0] ALL_HI  = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_n;
  logic         dma_compat;
  logic [N-1:0] ack_n;
  logic         bus_rst;
  logic         nmi;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(TCK/2) clk = ~clk;

  busown_arbiter #(.NSLOT(NSLOT)) uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .dma_compat(dma_compat),
    .ack_n(ack_n), .bus_rst(bus_rst), .nmi(nmi)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 200000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [N-1:0] own(int unsigned i);
    return ~(N'(1) << i);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ack(string tag, logic [N-1:0] exp);
    chk(tag, 32'(ack_n), 32'(exp));
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_req(int unsigned i, logic on);
    req_n[i] = ~on;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_n = '1;
    dma_compat = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk_ack("R1 reset ack", own(0));
    chk("R1 reset bus_rst", 32'(bus_rst), 0);
    chk("R1 reset nmi", 32'(nmi), 0);
  endtask

  task automatic t_idle_grant();
    do_reset();
    set_req(4, 1);
    step(1);
    chk_ack("R2 grant from idle cpu", own(4));
    set_req(4, 0);
    step(1);
    chk_ack("R11 return to cpu", own(0));
  endtask

  task automatic t_preempt();
    do_reset();
    set_req(4, 1);
    step(1);
    set_req(6, 1);
    step(1);
    chk_ack("R3 ack withdrawn", ALL_HI);
    step(3);
    chk_ack("R3 still waiting", ALL_HI);
    set_req(4, 0);
    step(1);
    chk_ack("R4 handoff after release", own(6));
  endtask

  task automatic t_rotation();
    do_reset();
    set_req(3, 1); set_req(5, 1); set_req(7, 1);
    step(1);
    chk_ack("R5 first after cpu", own(3));
    step(1);
    set_req(3, 0);
    step(1);
    chk_ack("R5 next after 3", own(5));
    step(1);
    set_req(5, 0);
    step(1);
    chk_ack("R5 next after 5", own(7));
    set_req(1, 1); set_req(3, 1);
    step(1);
    chk_ack("R3 slot 7 preempted", ALL_HI);
    set_req(7, 0);
    step(1);
    chk_ack("R5 wrap to refresh", own(1));
  endtask

  task automatic t_timeout(int unsigned who, int unsigned lim, string tag);
    do_reset();
    set_req(who, 1);
    step(1);
    set_req(who == 3 ? 4 : 3, 1);
    step(1);
    chk_ack({tag, " withdrawn"}, ALL_HI);
    step(int'(lim) - 1);
    chk({tag, " no reset before limit"}, 32'(bus_rst), 0);
    step(1);
    chk({tag, " bus_rst at limit R8"}, 32'(bus_rst), 1);
    chk({tag, " nmi at limit R8"}, 32'(nmi), 1);
    chk_ack({tag, " acks high in recovery R8"}, ALL_HI);
    req_n = '1;
    step(1);
    chk_ack("R8 cpu after timeout", own(0));
    chk("R8 bus_rst single clock", 32'(bus_rst), 0);
  endtask

  task automatic t_just_in_time();
    do_reset();
    set_req(3, 1);
    step(1);
    set_req(4, 1);
    step(1);
    step(int'(SLOT_LIM) - 1);
    set_req(3, 0);
    step(1);
    chk("R6 release on last edge no reset", 32'(bus_rst), 0);
    chk_ack("R6 release on last edge handoff", own(4));
  endtask

  task automatic t_dma_compat();
    int bad;
    do_reset();
    dma_compat = 1'b1;
    set_req(2, 1);
    step(1);
    chk_ack("R9 dma granted", own(2));
    set_req(5, 1);
    bad = 0;
    for (int k = 0; k < 100; k++) begin
      step(1);
      if (ack_n !== own(2) || bus_rst !== 1'b0) bad++;
    end
    chk("R9 dma kept bus", 32'(bad), 0);
    set_req(2, 0);
    step(1);
    chk_ack("R9 handoff after voluntary drop", own(5));
  endtask

  initial begin
    rst_n = 1'b0;
    req_n = '1;
    dma_compat = 1'b0;
    t_reset();
    t_idle_grant();
    t_preempt();
    t_rotation();
    t_timeout(3, SLOT_LIM, "R6 slot");
    t_timeout(2, DMA_LIM, "R7 dma");
    t_just_in_time();
    t_dma_compat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule